// File: doc/BRIEF.md
# Coarse Tile Depth Culling Unit

This unit stands in front of a full-resolution depth test and keeps one reduced-precision "farthest depth" word for every square screen tile. Each rasterized tile arrives with its coordinates and the smallest (nearest) 32-bit depth among its pixels. The unit reads the matching table word once. If even the nearest pixel lies behind the stored farthest depth, the tile is flagged as culled and needs no per-pixel depth read. Otherwise the tile goes downstream unchanged for the exact test. Depth grows with distance.

The table is refreshed through a separate update port. The downstream test reports the new farthest depth of a tile together with a flag telling whether every pixel passed. Only a full pass rewrites the word; a partial pass leaves it alone, so table writes stay rare. Precision drops from 32 bits to a smaller word in a conservative way: the incoming nearest depth is truncated toward zero, and the stored farthest depth is rounded away from zero, saturating at all ones. A visible pixel is therefore never discarded.

A control state machine has two states. `ST_WIPE` writes all ones into one table word per cycle. It is entered from reset (transition T_RESET) and from a `clr_i` pulse while running (T_CLEAR); a pulse during a wipe restarts it (T_RESTART). `ST_RUN` serves lookups and updates and is entered when the last word has been wiped (T_WIPE_DONE). Three counters record accepted tiles, culled tiles and update writes.

Top module: `czc_top`

## Requirements
- R1: After reset, and after a `clr_i` pulse, every table word holds all ones. `in_ready` stays low for the wipe, which writes one word per cycle and takes TILES_X*TILES_Y cycles after a `clr_i` pulse.
- R2: A tile accepted at a clock edge (`in_valid` and `in_ready` high) appears at the next edge on the output with `out_valid` high. Its `out_tx`, `out_ty` and `out_zmin` equal the accepted values.
- R3: `out_cull` is 1 exactly when bits [31:16] of the incoming nearest depth are greater than the stored 16-bit word of that tile. An equal value does not cull.
- R4: An update writes the upper 16 bits of its 32-bit farthest depth. The word is incremented when any of the lower 16 bits is set, and saturates at 0xFFFF.
- R5: An update with `upd_allpass` low changes neither the table nor `cnt_wr`.
- R6: An update changes only the word of its own tile, at index ty*TILES_X+tx.
- R7: When an update and a lookup target the same tile in the same cycle, the lookup uses the newly written value.
- R8: While `out_valid` is high and `out_ready` is low, the output fields hold steady and `in_ready` is low.
- R9: Reset zeroes the counters, and a clear does not change them. `cnt_seen` and `cnt_cull` step by one with each accepted and each culled tile, and are visible together with `out_valid`. `cnt_wr` steps once per table write from the update port, one cycle after the update.
- R10: Updates presented while a wipe is running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_i | input | 1 | Pulse that starts a table wipe |
| in_valid | input | 1 | Incoming tile valid |
| in_ready | output | 1 | Unit can accept a tile |
| in_tx | input | XW | Tile column |
| in_ty | input | YW | Tile row |
| in_zmin | input | ZW | Nearest depth of the tile |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts result |
| out_tx | output | XW | Tile column |
| out_ty | output | YW | Tile row |
| out_zmin | output | ZW | Nearest depth, unchanged |
| out_cull | output | 1 | 1 = whole tile hidden |
| upd_valid | input | 1 | Update valid |
| upd_tx | input | XW | Update tile column |
| upd_ty | input | YW | Update tile row |
| upd_allpass | input | 1 | Every pixel of the tile passed |
| upd_zmax | input | ZW | New farthest depth of the tile |
| cnt_seen | output | CW | Tiles accepted |
| cnt_cull | output | CW | Tiles culled |
| cnt_wr | output | CW | Table words written by updates |

## Verification
Lookup results, `cnt_seen` and `cnt_cull` are due one edge after acceptance. The bench drives on the falling edge and reads them at the next falling edge. Update writes act at the next rising edge, so `cnt_wr` and the effect on a lookup show from the following falling edge on. The same-cycle case is driven in a single falling edge. The wipe length is counted in falling edges with `in_ready` low, starting right after the `clr_i` edge, and must equal the tile count. Stall checks hold `out_ready` low for several cycles and compare the output fields on each of them.

// File: rtl/czc_pkg.sv
package czc_pkg;
    typedef enum logic [0:0] {
        ST_WIPE = 1'b0,
        ST_RUN  = 1'b1
    } czc_state_e;

    localparam int N_CNT = 3;
    localparam int CNT_SEEN = 0;
    localparam int CNT_CULL = 1;
    localparam int CNT_WR   = 2;
endpackage

// File: rtl/czc_quant.sv
module czc_quant #(
    parameter int ZW = 32,
    parameter int K  = 16
) (
    input  logic [ZW-1:0] zmin,
    input  logic [ZW-1:0] zmax,
    output logic [K-1:0]  zmin_q,
    output logic [K-1:0]  zmax_q
);
    generate
        if (K == ZW) begin : g_full
            assign zmin_q = zmin;
            assign zmax_q = zmax;
        end else begin : g_reduced
            localparam int S = ZW - K;
            logic [K-1:0] hi;
            logic         lo_set;
            logic         unused_lo;
            assign zmin_q    = zmin[ZW-1:S];
            assign unused_lo = ^zmin[S-1:0];
            assign hi        = zmax[ZW-1:S];
            assign lo_set    = |zmax[S-1:0];
            // round away from zero, saturating
            assign zmax_q    = (lo_set && (hi != '1)) ? hi + 1'b1 : hi;
        end
    endgenerate
endmodule

// File: rtl/czc_table.sv
module czc_table #(
    parameter int ENTRIES = 192,
    parameter int K       = 16,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [K-1:0]  wdata,
    input  logic [IW-1:0] ridx,
    output logic [K-1:0]  rdata
);
    logic [K-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdata;
    end

    // write-first forwarding for a same-cycle hit
    always_comb begin
        if (we && (widx == ridx)) rdata = wdata;
        else                      rdata = mem[ridx];
    end
endmodule

// File: rtl/czc_fsm.sv
module czc_fsm
    import czc_pkg::*;
#(
    parameter int ENTRIES = 192,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    output logic          run,
    output logic          wipe_we,
    output logic [IW-1:0] wipe_idx
);
    czc_state_e    state, state_nx;
    logic [IW-1:0] ptr, ptr_nx;
    localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

    always_comb begin
        state_nx = state;
        ptr_nx   = ptr;
        unique case (state)
            ST_WIPE: begin
                if (clr_i) begin
                    ptr_nx = '0;                 // T_RESTART
                end else if (ptr == LAST) begin
                    state_nx = ST_RUN;           // T_WIPE_DONE
                    ptr_nx   = '0;
                end else begin
                    ptr_nx = ptr + 1'b1;
                end
            end
            ST_RUN: begin
                if (clr_i) begin
                    state_nx = ST_WIPE;          // T_CLEAR
                    ptr_nx   = '0;
                end
            end
            default: state_nx = ST_WIPE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_WIPE;                    // T_RESET
            ptr   <= '0;
        end else begin
            state <= state_nx;
            ptr   <= ptr_nx;
        end
    end

    always_comb begin
        run      = 1'b0;
        wipe_we  = 1'b0;
        wipe_idx = ptr;
        unique case (state)
            ST_WIPE: wipe_we = 1'b1;
            ST_RUN:  run     = 1'b1;
            default: run     = 1'b0;
        endcase
    end
endmodule

// File: rtl/czc_stats.sv
module czc_stats
    import czc_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_CNT-1:0]     inc,
    output logic [N_CNT*CW-1:0]  cnt_flat
);
    generate
        for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
            logic [CW-1:0] c;
            always_ff @(posedge clk) begin
                if (!rst_n)      c <= '0;
                else if (inc[i]) c <= c + 1'b1;
            end
            assign cnt_flat[i*CW +: CW] = c;
        end
    endgenerate
endmodule

// File: rtl/czc_top.sv
module czc_top
    import czc_pkg::*;
#(
    parameter int TILE_PX = 4,
    parameter int SCR_W   = 64,
    parameter int SCR_H   = 48,
    parameter int ZW      = 32,
    parameter int K       = 16,
    parameter int CW      = 16,
    localparam int TILES_X = SCR_W / TILE_PX,
    localparam int TILES_Y = SCR_H / TILE_PX,
    localparam int NT      = TILES_X * TILES_Y,
    localparam int XW      = $clog2(TILES_X),
    localparam int YW      = $clog2(TILES_Y),
    localparam int IW      = $clog2(NT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [XW-1:0] in_tx,
    input  logic [YW-1:0] in_ty,
    input  logic [ZW-1:0] in_zmin,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [XW-1:0] out_tx,
    output logic [YW-1:0] out_ty,
    output logic [ZW-1:0] out_zmin,
    output logic          out_cull,
    input  logic          upd_valid,
    input  logic [XW-1:0] upd_tx,
    input  logic [YW-1:0] upd_ty,
    input  logic          upd_allpass,
    input  logic [ZW-1:0] upd_zmax,
    output logic [CW-1:0] cnt_seen,
    output logic [CW-1:0] cnt_cull,
    output logic [CW-1:0] cnt_wr
);
    logic          run, wipe_we;
    logic [IW-1:0] wipe_idx, rd_idx, up_idx, tb_widx;
    logic [K-1:0]  zmin_q, zmax_q, tb_wdata, tb_rdata;
    logic          upd_write, tb_we, accept, hit_cull;
    logic [N_CNT-1:0]    inc;
    logic [N_CNT*CW-1:0] cnt_flat;

    czc_fsm #(.ENTRIES(NT)) u_fsm (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
        .run(run), .wipe_we(wipe_we), .wipe_idx(wipe_idx)
    );

    czc_quant #(.ZW(ZW), .K(K)) u_quant (
        .zmin(in_zmin), .zmax(upd_zmax), .zmin_q(zmin_q), .zmax_q(zmax_q)
    );

    assign rd_idx = IW'(in_ty) * IW'(TILES_X) + IW'(in_tx);
    assign up_idx = IW'(upd_ty) * IW'(TILES_X) + IW'(upd_tx);

    assign upd_write = run && upd_valid && upd_allpass;
    assign tb_we     = wipe_we || upd_write;
    assign tb_widx   = wipe_we ? wipe_idx : up_idx;
    assign tb_wdata  = wipe_we ? {K{1'b1}} : zmax_q;

    czc_table #(.ENTRIES(NT), .K(K)) u_table (
        .clk(clk), .we(tb_we), .widx(tb_widx), .wdata(tb_wdata),
        .ridx(rd_idx), .rdata(tb_rdata)
    );

    assign in_ready = run && (!out_valid || out_ready);
    assign accept   = in_valid && in_ready;
    assign hit_cull = zmin_q > tb_rdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_tx    <= '0;
            out_ty    <= '0;
            out_zmin  <= '0;
            out_cull  <= 1'b0;
        end else begin
            if (out_ready || !out_valid) out_valid <= accept;
            if (accept) begin
                out_tx   <= in_tx;
                out_ty   <= in_ty;
                out_zmin <= in_zmin;
                out_cull <= hit_cull;
            end
        end
    end

    assign inc[CNT_SEEN] = accept;
    assign inc[CNT_CULL] = accept && hit_cull;
    assign inc[CNT_WR]   = upd_write;

    czc_stats #(.CW(CW)) u_stats (
        .clk(clk), .rst_n(rst_n), .inc(inc), .cnt_flat(cnt_flat)
    );

    assign cnt_seen = cnt_flat[CNT_SEEN*CW +: CW];
    assign cnt_cull = cnt_flat[CNT_CULL*CW +: CW];
    assign cnt_wr   = cnt_flat[CNT_WR*CW +: CW];
endmodule

// File: rtl/czc_sva.sv
module czc_sva #(
    parameter int XW = 4,
    parameter int YW = 4,
    parameter int ZW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clr_i,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [XW-1:0] out_tx,
    input logic [YW-1:0] out_ty,
    input logic [ZW-1:0] out_zmin,
    input logic          out_cull,
    input logic          upd_valid,
    input logic          upd_allpass,
    input logic [CW-1:0] cnt_seen,
    input logic [CW-1:0] cnt_cull,
    input logic [CW-1:0] cnt_wr
);
    p_wipe_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !in_ready);

    p_next_edge_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_tx) && $stable(out_ty)
                                       && $stable(out_zmin) && $stable(out_cull)));

    p_partial_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_allpass) |=> $stable(cnt_wr));

    p_seen_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (cnt_seen == $past(cnt_seen) + 1'b1));

    p_cull_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_cull <= cnt_seen);
endmodule

bind czc_top czc_sva #(.XW(XW), .YW(YW), .ZW(ZW), .CW(CW)) u_sva (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .in_valid(in_valid),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_tx(out_tx), .out_ty(out_ty), .out_zmin(out_zmin), .out_cull(out_cull),
    .upd_valid(upd_valid), .upd_allpass(upd_allpass),
    .cnt_seen(cnt_seen), .cnt_cull(cnt_cull), .cnt_wr(cnt_wr)
);

// File: tb/tb_czc_top.sv
`timescale 1ns/1ps
module tb_czc_top;
    localparam int NT = 16 * 12;

    logic        clk = 0, rst_n = 0, clr_i = 0;
    logic        in_valid = 0, out_ready = 1;
    logic [3:0]  in_tx = 0, in_ty = 0, upd_tx = 0, upd_ty = 0;
    logic [31:0] in_zmin = 0, upd_zmax = 0;
    logic        upd_valid = 0, upd_allpass = 0;
    logic        in_ready, out_valid, out_cull;
    logic [3:0]  out_tx, out_ty;
    logic [31:0] out_zmin;
    logic [15:0] cnt_seen, cnt_cull, cnt_wr;

    int nchk = 0, nerr = 0;
    int e_seen = 0, e_cull = 0, e_wr = 0;

    always #2.5 clk = ~clk;

    czc_top dut (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
        .in_valid(in_valid), .in_ready(in_ready), .in_tx(in_tx), .in_ty(in_ty),
        .in_zmin(in_zmin), .out_valid(out_valid), .out_ready(out_ready),
        .out_tx(out_tx), .out_ty(out_ty), .out_zmin(out_zmin), .out_cull(out_cull),
        .upd_valid(upd_valid), .upd_tx(upd_tx), .upd_ty(upd_ty),
        .upd_allpass(upd_allpass), .upd_zmax(upd_zmax),
        .cnt_seen(cnt_seen), .cnt_cull(cnt_cull), .cnt_wr(cnt_wr)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_counts(input string req);
        chk(cnt_seen == 16'(e_seen), {req, " cnt_seen"}, cnt_seen, e_seen);
        chk(cnt_cull == 16'(e_cull), {req, " cnt_cull"}, cnt_cull, e_cull);
        chk(cnt_wr   == 16'(e_wr),   {req, " cnt_wr"},   cnt_wr,   e_wr);
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!in_ready && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic lookup(input int tx, input int ty, input logic [31:0] z,
                          input bit exp_cull, input string req);
        @(negedge clk);
        chk(in_ready, {req, " in_ready before lookup"}, in_ready, 1);
        in_valid = 1; in_tx = 4'(tx); in_ty = 4'(ty); in_zmin = z; out_ready = 1;
        @(negedge clk);
        in_valid = 0;
        e_seen++;
        if (exp_cull) e_cull++;
        chk(out_valid, {req, " R2 out_valid"}, out_valid, 1);
        chk(out_tx == 4'(tx) && out_ty == 4'(ty) && out_zmin == z,
            {req, " R2 fields"}, {out_tx, out_ty, out_zmin}, {4'(tx), 4'(ty), z});
        chk(out_cull == exp_cull, {req, " out_cull"}, out_cull, exp_cull);
        check_counts({req, " R9"});
    endtask

    task automatic update(input int tx, input int ty, input logic [31:0] zmax,
                          input bit allpass, input bit counted);
        @(negedge clk);
        upd_valid = 1; upd_tx = 4'(tx); upd_ty = 4'(ty);
        upd_zmax = zmax; upd_allpass = allpass;
        @(negedge clk);
        upd_valid = 0; upd_allpass = 0;
        if (counted) e_wr++;
    endtask

    task automatic t_reset();
        int n;
        chk(!out_valid, "R9 reset out_valid", out_valid, 0);
        chk(!in_ready, "R1 ready low in wipe", in_ready, 0);
        check_counts("R9 reset");
        wait_ready(n);
        chk(n >= NT - 2 && n <= NT, "R1 wipe length after reset", n, NT);
        lookup(15, 11, 32'hFFFF_FFFF, 0, "R1 reset fills all ones");
    endtask

    task automatic t_cull_rule();
        update(2, 3, 32'h4000_0000, 1, 1);
        check_counts("R9 write count");
        lookup(2, 3, 32'h4001_0000, 1, "R3 farther culls");
        lookup(2, 3, 32'h4000_FFFF, 0, "R3 equal keeps");
        lookup(2, 3, 32'h1000_0000, 0, "R3 nearer keeps");
        lookup(3, 2, 32'h4001_0000, 0, "R6 neighbour untouched");
    endtask

    task automatic t_round();
        update(7, 1, 32'h4000_0001, 1, 1);
        lookup(7, 1, 32'h4001_FFFF, 0, "R4 round up keeps");
        lookup(7, 1, 32'h4002_0000, 1, "R4 above rounded culls");
        update(8, 1, 32'hFFFF_0001, 1, 1);
        lookup(8, 1, 32'hFFFF_FFFF, 0, "R4 saturate");
    endtask

    task automatic t_partial();
        update(2, 3, 32'h0000_0000, 0, 0);
        @(negedge clk);
        check_counts("R5 partial");
        lookup(2, 3, 32'h4001_0000, 1, "R5 partial leaves entry");
    endtask

    task automatic t_bypass();
        @(negedge clk);
        upd_valid = 1; upd_tx = 5; upd_ty = 5; upd_zmax = 32'h1000_0000; upd_allpass = 1;
        in_valid = 1; in_tx = 5; in_ty = 5; in_zmin = 32'h2000_0000;
        @(negedge clk);
        upd_valid = 0; upd_allpass = 0; in_valid = 0;
        e_wr++; e_seen++; e_cull++;
        chk(out_valid && out_cull, "R7 same-cycle sees new value", out_cull, 1);
        check_counts("R7 R9");
    endtask

    task automatic t_stall();
        @(negedge clk);
        out_ready = 0;
        in_valid = 1; in_tx = 1; in_ty = 1; in_zmin = 32'h0000_1234;
        @(negedge clk);
        e_seen++;
        in_tx = 9; in_ty = 4; in_zmin = 32'h0000_5678;
        for (int i = 0; i < 3; i++) begin
            chk(out_valid && out_tx == 1 && out_ty == 1 && out_zmin == 32'h1234,
                "R8 held", out_zmin, 32'h1234);
            chk(!in_ready, "R8 in_ready low", in_ready, 0);
            @(negedge clk);
        end
        out_ready = 1;
        @(negedge clk);
        in_valid = 0;
        e_seen++;
        chk(out_valid && out_tx == 9 && out_ty == 4 && out_zmin == 32'h5678,
            "R8 second after release", out_zmin, 32'h5678);
        check_counts("R8 R9");
    endtask

    task automatic t_clear();
        int n;
        @(negedge clk);
        clr_i = 1;
        @(negedge clk);
        clr_i = 0;
        chk(!in_ready, "R1 ready low after clear", in_ready, 0);
        upd_valid = 1; upd_allpass = 1; upd_tx = 2; upd_ty = 3; upd_zmax = 0;
        @(negedge clk);
        upd_valid = 0; upd_allpass = 0;
        n = 1;
        while (!in_ready && n < 1000) begin
            @(negedge clk);
            n++;
        end
        chk(n == NT, "R1 wipe length after clear", n, NT);
        check_counts("R9 R10 clear keeps counters");
        lookup(2, 3, 32'h4001_0000, 0, "R10 R1 entry cleared, update ignored");
        lookup(5, 5, 32'hFFFF_FFFF, 0, "R1 cleared");
    endtask

    initial begin : wdog
        repeat (20000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_cull_rule();
        t_round();
        t_partial();
        t_bypass();
        t_stall();
        t_clear();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule